// File: doc/BRIEF.md
# Sparse Row Dot Product over Replicated Dense Storage

This block computes one row of a sparse matrix times dense vector product. A row is a fixed number of (index, value) entries. The dense vector has one item per system unknown. The block returns the sum over all entries of value times the dense item at that entry's index.

The dense vector is stored as words of several items each. Every sparse entry has its own synchronous memory copy holding the whole dense vector, so all entries fetch in the same cycle. Each index is split into a word address and an item position inside the word. The address goes to that entry's copy. The item position is registered next to the read, and one cycle later a small selector picks the item out of the returned word. The products are added and registered, and a one-cycle pulse marks the result.

A single write port updates one dense item in every copy at once, so the copies always hold the same data. A row request can be issued every cycle. A write and a request in the same cycle is not allowed: the block flags it and discards the request.

Top module: `sdl_row_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_valid` and `collide` are 0 and `rsp_sum` is 0.
- R2: An accepted row returns the full-precision signed sum of `val_k * dense[idx_k]` over all entries. Values and dense items are 16-bit two's complement, and the sum is 35 bits, sign-extended.
- R3: A request accepted in cycle c gives `rsp_valid` high in cycle c+2 only, with `rsp_sum` valid in that cycle.
- R4: Requests in consecutive cycles each give their own result, in consecutive cycles and in issue order.
- R5: A write of (`wr_idx`, `wr_val`) replaces only that item, in all copies. The other items in the same word are unchanged. A request in the following cycle sees the new value.
- R6: Index `i` maps to word `i / 4` and position `i % 4`. Entries in one row may share a word or an index, and each still gets its own item.
- R7: `wr_en` and `req_valid` high in the same cycle drives `collide` high in the next cycle. The write is applied, and the request produces no response.
- R8: While `rsp_valid` is low, `rsp_sum` holds its last value.
- R9: Entry k's index is `req_idx[6k+5:6k]` and its value is `req_val[16k+15:16k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one dense item |
| wr_idx | input | 6 | Dense item index to write |
| wr_val | input | 16 | Signed item value |
| req_valid | input | 1 | Row request |
| req_idx | input | 30 | Packed entry indices (6 bits per entry) |
| req_val | input | 80 | Packed signed entry values (16 bits per entry) |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_sum | output | 35 | Signed row dot product |
| collide | output | 1 | Write and request arrived in the same cycle |

## Verification
Three situations are hard to reach from the ports:
- **Write then read at once.** A write is followed in the very next cycle by a row that reads the written item and its word neighbours. This shows that the update landed in every copy and touched only its own position.
- **Collision.** A write and a request are driven in the same cycle. The scoreboard expects no response, and a follow-up row confirms the write took effect.
- **Dense streams.** Unbroken request streams, with rows that repeat a word or an index across entries, exercise the per-entry position registers under full pipeline load.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam int unsigned DEF_ITEMS   = 64;
  localparam int unsigned DEF_BLK     = 4;
  localparam int unsigned DEF_ENTRIES = 5;
  localparam int unsigned DEF_VW      = 16;
endpackage

// File: rtl/sdl_block_mem.sv
module sdl_block_mem #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned BLK   = 4,
  parameter int unsigned VW    = 16,
  parameter int unsigned AW    = 4,
  parameter int unsigned OW    = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [OW-1:0]     wr_lane,
  input  logic [VW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [BLK*VW-1:0] rd_word
);
  logic [BLK*VW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr][wr_lane*VW +: VW] <= wr_data;
    if (rd_en) rd_word <= store[rd_addr];
  end
endmodule

// File: rtl/sdl_lane.sv
module sdl_lane #(
  parameter int unsigned ITEMS = 64,
  parameter int unsigned BLK   = 4,
  parameter int unsigned VW    = 16,
  localparam int unsigned IW    = $clog2(ITEMS),
  localparam int unsigned OW    = $clog2(BLK),
  localparam int unsigned DEPTH = ITEMS / BLK,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned PW    = 2 * VW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [VW-1:0]        wr_val,
  input  logic                 rd_en,
  input  logic [IW-1:0]        idx,
  input  logic [VW-1:0]        val,
  output logic signed [PW-1:0] prod
);
  function automatic logic [AW-1:0] word_of(input logic [IW-1:0] i);
    return AW'(i / BLK);
  endfunction

  function automatic logic [OW-1:0] pos_of(input logic [IW-1:0] i);
    return OW'(i % BLK);
  endfunction

  function automatic logic signed [PW-1:0] mul_s(input logic [VW-1:0] a,
                                                 input logic [VW-1:0] b);
    return PW'($signed(a) * $signed(b));
  endfunction

  logic [BLK*VW-1:0] word_q;
  logic [OW-1:0]     pos_q;
  logic [VW-1:0]     val_q;
  logic [VW-1:0]     elem;

  sdl_block_mem #(.DEPTH(DEPTH), .BLK(BLK), .VW(VW), .AW(AW), .OW(OW)) mem_i (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (word_of(wr_idx)),
    .wr_lane (pos_of(wr_idx)),
    .wr_data (wr_val),
    .rd_en   (rd_en),
    .rd_addr (word_of(idx)),
    .rd_word (word_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      val_q <= '0;
    end else if (rd_en) begin
      pos_q <= pos_of(idx);
      val_q <= val;
    end
  end

  assign elem = word_q[pos_q*VW +: VW];
  assign prod = mul_s(elem, val_q);
endmodule

// File: rtl/sdl_prod_sum.sv
module sdl_prod_sum #(
  parameter int unsigned ENTRIES = 5,
  parameter int unsigned PW      = 32,
  parameter int unsigned ACC_W   = 35
) (
  input  logic [ENTRIES*PW-1:0]   prods,
  output logic signed [ACC_W-1:0] sum
);
  function automatic logic signed [ACC_W-1:0] widen(input logic [PW-1:0] p);
    return ACC_W'($signed(p));
  endfunction

  always_comb begin
    sum = '0;
    for (int k = 0; k < ENTRIES; k++) sum = sum + widen(prods[k*PW +: PW]);
  end
endmodule

// File: rtl/sdl_row_engine.sv
module sdl_row_engine #(
  parameter int unsigned ITEMS   = sdl_pkg::DEF_ITEMS,
  parameter int unsigned BLK     = sdl_pkg::DEF_BLK,
  parameter int unsigned ENTRIES = sdl_pkg::DEF_ENTRIES,
  parameter int unsigned VW      = sdl_pkg::DEF_VW,
  localparam int unsigned IW     = $clog2(ITEMS),
  localparam int unsigned PW     = 2 * VW,
  localparam int unsigned ACC_W  = PW + $clog2(ENTRIES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IW-1:0]           wr_idx,
  input  logic [VW-1:0]           wr_val,
  input  logic                    req_valid,
  input  logic [ENTRIES*IW-1:0]   req_idx,
  input  logic [ENTRIES*VW-1:0]   req_val,
  output logic                    rsp_valid,
  output logic signed [ACC_W-1:0] rsp_sum,
  output logic                    collide
);
  logic                    accept;
  logic                    clash;
  logic                    st1_valid;
  logic [ENTRIES*PW-1:0]   prods;
  logic signed [ACC_W-1:0] row_sum;

  assign accept = req_valid & ~wr_en;
  assign clash  = req_valid & wr_en;

  for (genvar k = 0; k < ENTRIES; k++) begin : g_lane
    sdl_lane #(.ITEMS(ITEMS), .BLK(BLK), .VW(VW)) lane_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_val (wr_val),
      .rd_en  (accept),
      .idx    (req_idx[k*IW +: IW]),
      .val    (req_val[k*VW +: VW]),
      .prod   (prods[k*PW +: PW])
    );
  end

  sdl_prod_sum #(.ENTRIES(ENTRIES), .PW(PW), .ACC_W(ACC_W)) sum_i (
    .prods (prods),
    .sum   (row_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st1_valid <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_sum   <= '0;
      collide   <= 1'b0;
    end else begin
      st1_valid <= accept;
      rsp_valid <= st1_valid;
      collide   <= clash;
      if (st1_valid) rsp_sum <= row_sum;
    end
  end

  // R3
  rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !wr_en, 2));

  // R3
  rsp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !wr_en) |=> ##1 rsp_valid);

  // R7
  clash_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && wr_en) |=> collide);

  // R7
  clash_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> !rsp_valid);

  // R8
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_sum));
endmodule

// File: tb/sdl_row_engine_tb.sv
module sdl_row_engine_tb_top;
  localparam int N = 64;
  localparam int E = 5;
  localparam int IW = 6;
  localparam int VW = 16;
  localparam int AW = 35;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [VW-1:0] wr_val = '0;
  logic          req_valid = 1'b0;
  logic [E*IW-1:0] req_idx = '0;
  logic [E*VW-1:0] req_val = '0;
  logic          rsp_valid;
  logic [AW-1:0] rsp_sum;
  logic          collide;

  always #4 clk = ~clk;

  sdl_row_engine dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .req_valid(req_valid), .req_idx(req_idx), .req_val(req_val),
    .rsp_valid(rsp_valid), .rsp_sum(rsp_sum), .collide(collide)
  );

  typedef struct { longint sum; int due; string tag; } exp_t;
  exp_t   sb [$];
  longint dense [N];
  int     cyc = 0;
  int     n_chk = 0;
  int     n_bad = 0;
  bit     done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check("R3 unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " R3 timing"}, cyc, e.due);
        check({e.tag, " R2 sum"}, longint'($signed(rsp_sum)), e.sum);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      wr_en = 0; req_valid = 0;
      @(negedge clk);
    end
  endtask

  // caller is at a negedge; leaves inputs driven for one cycle
  task automatic wr(int idx, longint v);
    wr_en = 1; req_valid = 0;
    wr_idx = IW'(idx); wr_val = VW'(v);
    dense[idx] = longint'($signed(VW'(v)));
    @(negedge clk);
  endtask

  task automatic req(int ix [E], longint vv [E], string tag);
    exp_t e;
    longint s = 0;
    for (int k = 0; k < E; k++) begin
      req_idx[k*IW +: IW] = IW'(ix[k]);           // R9 packing
      req_val[k*VW +: VW] = VW'(vv[k]);
      s += longint'($signed(VW'(vv[k]))) * dense[ix[k]];
    end
    wr_en = 0; req_valid = 1;
    e.sum = s; e.due = cyc + 2; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int ix [E];
    longint vv [E];
    longint held;
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", rsp_valid, 0);
    check("R1 collide in reset", collide, 0);
    check("R1 rsp_sum in reset", rsp_sum, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 rsp_valid after reset", rsp_valid, 0);
    check("R1 rsp_sum after reset", rsp_sum, 0);

    for (int i = 0; i < N; i++) wr(i, (i * 523) % 4000 - 2000);
    wr(0, 32767);
    wr(63, -32768);
    idle(1);

    // R2, R9: distinct indices, distinct values per entry
    ix = '{0, 2, 13, 38, 61}; vv = '{1, -2, 300, -4000, 32767};
    req(ix, vv, "R9 spread row");
    idle(3);

    // R6: shared word, repeated index
    ix = '{4, 5, 6, 7, 5}; vv = '{10, -20, 30, -40, 50};
    req(ix, vv, "R6 shared word");
    idle(3);

    // R2: extreme magnitude
    ix = '{63, 63, 63, 63, 63}; vv = '{-32768, -32768, -32768, -32768, -32768};
    req(ix, vv, "R2 max positive");
    ix = '{63, 0, 63, 0, 63}; vv = '{32767, -32768, 32767, -32768, 32767};
    req(ix, vv, "R2 max negative");
    idle(3);

    // R4: back-to-back stream
    for (int r = 0; r < 12; r++) begin
      for (int k = 0; k < E; k++) begin
        ix[k] = (r * 11 + k * 17) % N;
        vv[k] = (r * 977 + k * 3001) % 20000 - 10000;
      end
      req(ix, vv, "R4 stream");
    end
    idle(3);

    // R5: write then read next cycle, neighbours untouched
    wr(22, -1234);
    ix = '{20, 21, 22, 23, 22}; vv = '{1, 1, 1000, 1, -3};
    req(ix, vv, "R5 write then read");
    ix = '{20, 20, 20, 20, 20}; vv = '{1, 0, 0, 0, 0};
    req(ix, vv, "R5 neighbour low");
    ix = '{23, 23, 23, 23, 23}; vv = '{0, 0, 0, 0, 1};
    req(ix, vv, "R5 neighbour high");
    idle(3);

    // R7: collision
    ix = '{10, 11, 12, 13, 14}; vv = '{5, 5, 5, 5, 5};
    for (int k = 0; k < E; k++) begin
      req_idx[k*IW +: IW] = IW'(ix[k]);
      req_val[k*VW +: VW] = VW'(vv[k]);
    end
    wr_idx = IW'(10); wr_val = VW'(777); dense[10] = 777;
    wr_en = 1; req_valid = 1;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    check("R7 collide flag", collide, 1);
    @(negedge clk);
    check("R7 collide one cycle", collide, 0);
    check("R7 no response from dropped request", rsp_valid, 0);
    ix = '{10, 10, 10, 10, 10}; vv = '{1, 0, 0, 0, 0};
    req(ix, vv, "R7 write applied");
    idle(3);

    // R8: hold while idle
    held = longint'($signed(rsp_sum));
    idle(4);
    check("R8 sum held", longint'($signed(rsp_sum)), held);
    check("R8 valid low when idle", rsp_valid, 0);
    check("R4 scoreboard drained", sb.size(), 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule